// File: doc/BRIEF.md
# Load-Use Hazard Stall Unit

This block watches the boundary between the decode and execute stages of a five-stage in-order pipeline. It raises a one-cycle stall when the instruction in execute is a load whose destination register is also a source of the instruction in decode. While the stall is up, the program counter and the fetch/decode register are frozen and an all-zero control bundle enters the decode/execute register. That empty slot moves down the pipeline as a bubble. After the bubble, the loaded value is available to forwarding logic, which lies outside this block.

The detector sits inside a small harness: a program counter, a fetch/decode register, a control decoder and a decode/execute register. The bubble, the frozen stages and the resumed flow are therefore all visible at the ports cycle by cycle. The caller acts as instruction memory. It presents the word at the current program counter on `fetch_instr`.

Top module: `lu_stall_harness`

## Requirements
- R1: `stall` is 1 whenever the decode/execute memory-read flag is 1 and the decode/execute rt number equals the rs field (bits 25:21) of the fetch/decode instruction.
- R2: `stall` is also 1 when the decode/execute memory-read flag is 1 and the decode/execute rt number equals the rt field (bits 20:16) of the fetch/decode instruction.
- R3: When the decode/execute memory-read flag is 0, `stall` is 0 whatever the register numbers are.
- R4: `pc_we` and `ifid_we` are the inverse of `stall`. In a stall cycle the next clock edge leaves `pc_addr` and `ifid_instr` unchanged.
- R5: On the clock edge after a stall cycle, `idex_ctrl` becomes 8'h00, which is a bubble.
- R6: Without a stall, each clock edge advances `pc_addr` by 4, loads `fetch_instr` into `ifid_instr`, and copies the decoded control bundle of `ifid_instr` into `idex_ctrl`. It also copies the rs and rt fields into `idex_rs` and `idex_rt`.
- R7: The control bundle layout, from bit 7 down to bit 0, is: register write, memory-to-register, memory read, memory write, register destination select, ALU source select, and a two-bit ALU op. The opcode is in bits 31:26. Opcode 6'h23 (load) decodes to 8'hE4, 6'h2B (store) to 8'h14, 6'h00 (register form) to 8'h8A, and any other opcode to 8'h00.
- R8: A load followed by two back-to-back instructions that both read its destination produces exactly one bubble cycle. A stall is never held for two cycles in a row.
- R9: A synchronous active-low reset clears `pc_addr`, `ifid_instr`, `idex_ctrl`, `idex_rs` and `idex_rt` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_instr | input | 32 | Instruction word at the current program counter |
| pc_addr | output | PC_W | Program counter |
| pc_we | output | 1 | Program counter update enable |
| ifid_we | output | 1 | Fetch/decode register load enable |
| stall | output | 1 | Load-use hazard detected; also zeroes the control bundle entering decode/execute |
| ifid_instr | output | 32 | Instruction held in fetch/decode |
| idex_ctrl | output | 8 | Control bundle held in decode/execute |
| idex_rs | output | 5 | rs number held in decode/execute |
| idex_rt | output | 5 | rt number held in decode/execute |

## Verification
The detector is tried with a load followed by an instruction that matches it only on rs, and then with one that matches only on rt. These two cases separate the two comparisons. A load followed by an instruction with no matching register shows that a load alone does not stall. A register-form instruction and a store each followed by a matching reader show that a register match without a memory read is ignored. A load whose destination equals both sources of the next instruction is also tried. A three-instruction chain, a load with two dependent instructions behind it, tells a single bubble apart from a repeated stall, and the final program counter confirms the one-cycle cost.

// File: rtl/lu_pkg.sv
// Package lu_pkg
// Shared field positions, opcodes and the control bundle type used by the
// load-use stall harness. Assumes a 32-bit fixed-format instruction word.
package lu_pkg;
    localparam int INSTR_W = 32;
    localparam int REG_W   = 5;
    localparam int OP_W    = 6;
    localparam int OP_LSB  = 26;
    localparam int RS_LSB  = 21;
    localparam int RT_LSB  = 16;

    localparam logic [OP_W-1:0] OP_REG   = 6'h00;
    localparam logic [OP_W-1:0] OP_LOAD  = 6'h23;
    localparam logic [OP_W-1:0] OP_STORE = 6'h2B;

    typedef struct packed {
        logic reg_write;
        logic mem_to_reg;
    } wb_ctrl_t;

    typedef struct packed {
        logic mem_read;
        logic mem_write;
    } mem_ctrl_t;

    typedef struct packed {
        logic       reg_dst;
        logic       alu_src;
        logic [1:0] alu_op;
    } ex_ctrl_t;

    typedef struct packed {
        wb_ctrl_t  wb;
        mem_ctrl_t mem;
        ex_ctrl_t  ex;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/lu_hazard_detect.sv
// Module lu_hazard_detect
// Purely combinational load-use detector. It compares the destination of a
// load in execute with both sources of the instruction in decode. Assumes
// the memory-read flag marks loads only.
module lu_hazard_detect
    import lu_pkg::*;
(
    input  logic             ex_mem_read,
    input  logic [REG_W-1:0] ex_rt,
    input  logic [REG_W-1:0] id_rs,
    input  logic [REG_W-1:0] id_rt,
    output logic             stall
);
    logic hit_rs;
    logic hit_rt;

    // Compare the load destination against each source field.
    always_comb begin
        hit_rs = (ex_rt == id_rs);
        hit_rt = (ex_rt == id_rt);
        stall  = ex_mem_read & (hit_rs | hit_rt);
    end
endmodule

// File: rtl/lu_ctrl_decode.sv
// Module lu_ctrl_decode
// Maps an opcode to the EX/MEM/WB control bundle. Opcodes it does not know
// decode to an all-zero bundle, which behaves as a nop.
module lu_ctrl_decode
    import lu_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output ctrl_t           ctrl
);
    // Select the bundle for the opcode.
    always_comb begin
        ctrl = '0;
        unique case (opcode)
            OP_LOAD: begin
                ctrl.wb.reg_write   = 1'b1;
                ctrl.wb.mem_to_reg  = 1'b1;
                ctrl.mem.mem_read   = 1'b1;
                ctrl.ex.alu_src     = 1'b1;
            end
            OP_STORE: begin
                ctrl.mem.mem_write  = 1'b1;
                ctrl.ex.alu_src     = 1'b1;
            end
            OP_REG: begin
                ctrl.wb.reg_write   = 1'b1;
                ctrl.ex.reg_dst     = 1'b1;
                ctrl.ex.alu_op      = 2'b10;
            end
            default: ctrl = '0;
        endcase
    end
endmodule

// File: rtl/lu_stage_regs.sv
// Module lu_pc_reg
// Program counter. It steps by one instruction width when enabled and holds
// otherwise. Synchronous active-low reset to zero.
module lu_pc_reg #(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    output logic [PC_W-1:0] pc
);
    localparam int STEP = lu_pkg::INSTR_W / 8;

    // Advance or hold the program counter.
    always_ff @(posedge clk) begin
        if (!rst_n)  pc <= '0;
        else if (we) pc <= pc + PC_W'(STEP);
    end
endmodule

// Module lu_ifid_reg
// Fetch/decode pipeline register. It loads the fetched word when enabled.
// Synchronous active-low reset to zero.
module lu_ifid_reg
    import lu_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [INSTR_W-1:0] instr_in,
    output logic [INSTR_W-1:0] instr_q
);
    // Capture or hold the fetched instruction.
    always_ff @(posedge clk) begin
        if (!rst_n)  instr_q <= '0;
        else if (we) instr_q <= instr_in;
    end
endmodule

// Module lu_idex_reg
// Decode/execute pipeline register. It loads every cycle. When zero_ctrl is
// set, an all-zero control bundle is stored instead of the decoded one.
module lu_idex_reg
    import lu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             zero_ctrl,
    input  ctrl_t            ctrl_in,
    input  logic [REG_W-1:0] rs_in,
    input  logic [REG_W-1:0] rt_in,
    output ctrl_t            ctrl_q,
    output logic [REG_W-1:0] rs_q,
    output logic [REG_W-1:0] rt_q
);
    ctrl_t ctrl_mux;

    // Replace the bundle with a bubble when asked to.
    always_comb ctrl_mux = zero_ctrl ? ctrl_t'('0) : ctrl_in;

    // Capture the bundle and the source register numbers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            rs_q   <= '0;
            rt_q   <= '0;
        end else begin
            ctrl_q <= ctrl_mux;
            rs_q   <= rs_in;
            rt_q   <= rt_in;
        end
    end
endmodule

// File: rtl/lu_stall_harness.sv
// Module lu_stall_harness
// Top level. It wires the load-use detector to a program counter and the
// fetch/decode and decode/execute registers, so the stall and the bubble it
// inserts can be seen at the ports. The caller supplies the instruction at
// pc_addr on fetch_instr.
module lu_stall_harness
    import lu_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] fetch_instr,
    output logic [PC_W-1:0]    pc_addr,
    output logic               pc_we,
    output logic               ifid_we,
    output logic               stall,
    output logic [INSTR_W-1:0] ifid_instr,
    output logic [CTRL_W-1:0]  idex_ctrl,
    output logic [REG_W-1:0]   idex_rs,
    output logic [REG_W-1:0]   idex_rt
);
    logic [REG_W-1:0] id_rs;
    logic [REG_W-1:0] id_rt;
    logic [OP_W-1:0]  id_op;
    ctrl_t            id_ctrl;
    ctrl_t            ex_ctrl;

    // Slice the decode-stage fields.
    always_comb begin
        id_op = ifid_instr[OP_LSB +: OP_W];
        id_rs = ifid_instr[RS_LSB +: REG_W];
        id_rt = ifid_instr[RT_LSB +: REG_W];
    end

    lu_hazard_detect u_hazard (
        .ex_mem_read (ex_ctrl.mem.mem_read),
        .ex_rt       (idex_rt),
        .id_rs       (id_rs),
        .id_rt       (id_rt),
        .stall       (stall)
    );

    // Freeze fetch and decode while a stall is up.
    always_comb begin
        pc_we   = ~stall;
        ifid_we = ~stall;
    end

    lu_pc_reg #(.PC_W(PC_W)) u_pc (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (pc_we),
        .pc    (pc_addr)
    );

    lu_ifid_reg u_ifid (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (ifid_we),
        .instr_in (fetch_instr),
        .instr_q  (ifid_instr)
    );

    lu_ctrl_decode u_dec (
        .opcode (id_op),
        .ctrl   (id_ctrl)
    );

    lu_idex_reg u_idex (
        .clk       (clk),
        .rst_n     (rst_n),
        .zero_ctrl (stall),
        .ctrl_in   (id_ctrl),
        .rs_in     (id_rs),
        .rt_in     (id_rt),
        .ctrl_q    (ex_ctrl),
        .rs_q      (idex_rs),
        .rt_q      (idex_rt)
    );

    // Present the execute-stage bundle at the port.
    always_comb idex_ctrl = ex_ctrl;

    // R3: a bundle without a memory read never causes a stall.
    assert_noload_nostall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_ctrl.mem.mem_read |-> !stall);

    // R4: a stall holds the program counter and the fetch/decode register.
    assert_stall_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(pc_addr) && $stable(ifid_instr)));

    // R5: the stage after a stall holds a bubble.
    assert_bubble_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (idex_ctrl == '0));

    // R6: without a stall the program counter steps by one word.
    assert_pc_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |=> (pc_addr == $past(pc_addr) + PC_W'(INSTR_W / 8)));

    // R8: a stall never lasts two cycles in a row.
    assert_single_bubble_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);

    // R9: reset clears the pipeline registers.
    assert_reset_clear_R9: assert property (@(posedge clk)
        !rst_n |=> (pc_addr == '0 && ifid_instr == '0 && idex_ctrl == '0
                    && idex_rs == '0 && idex_rt == '0));
endmodule

// File: tb/lu_stall_harness_test.sv
module lu_stall_harness_test;
    localparam int CLK_PERIOD = 10;
    localparam int PC_W = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_instr = '0;
    logic [PC_W-1:0] pc_addr;
    logic        pc_we, ifid_we, stall;
    logic [31:0] ifid_instr;
    logic [7:0]  idex_ctrl;
    logic [4:0]  idex_rs, idex_rt;

    int tests = 0;
    int fails = 0;
    bit done = 0;
    logic [31:0] prog [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    lu_stall_harness #(.PC_W(PC_W)) uut (
        .clk(clk), .rst_n(rst_n), .fetch_instr(fetch_instr),
        .pc_addr(pc_addr), .pc_we(pc_we), .ifid_we(ifid_we), .stall(stall),
        .ifid_instr(ifid_instr), .idex_ctrl(idex_ctrl),
        .idex_rs(idex_rs), .idex_rt(idex_rt)
    );

    function automatic logic [31:0] enc(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [4:0] rd);
        return {op, rs, rt, rd, 11'd0};
    endfunction

    // Expected control bundle from the R7 encoding.
    function automatic logic [7:0] exp_ctrl(input logic [31:0] ins);
        case (ins[31:26])
            6'h23:   return 8'hE4;
            6'h2B:   return 8'h14;
            6'h00:   return 8'h8A;
            default: return 8'h00;
        endcase
    endfunction

    typedef struct packed {
        logic [31:0] first;
        logic [31:0] second;
        logic        stall;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{enc(6'h23, 5'd3, 5'd2, 5'd0), enc(6'h00, 5'd2, 5'd5, 5'd12), 1'b1},  // R1 rs match
        '{enc(6'h23, 5'd3, 5'd2, 5'd0), enc(6'h00, 5'd3, 5'd2, 5'd12), 1'b1},  // R2 rt match
        '{enc(6'h23, 5'd3, 5'd2, 5'd0), enc(6'h00, 5'd3, 5'd4, 5'd12), 1'b0},  // no match
        '{enc(6'h00, 5'd1, 5'd2, 5'd9), enc(6'h00, 5'd2, 5'd2, 5'd12), 1'b0},  // R3 reg form
        '{enc(6'h2B, 5'd1, 5'd2, 5'd0), enc(6'h00, 5'd2, 5'd6, 5'd12), 1'b0},  // R3 store
        '{enc(6'h23, 5'd1, 5'd7, 5'd0), enc(6'h00, 5'd7, 5'd7, 5'd12), 1'b1}   // both match
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic refetch();
        fetch_instr = (pc_addr < 32) ? prog[pc_addr[4:2]] : 32'h0;
    endtask

    task automatic step();
        @(posedge clk);
        #2;
        refetch();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
    endtask

    task automatic load_prog(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
        for (int i = 0; i < 8; i++) prog[i] = 32'h0;
        prog[0] = a;
        prog[1] = b;
        prog[2] = c;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int nstall;
        load_prog(32'h0, 32'h0, 32'h0);
        do_reset();
        // R9 reset state
        chk("R9 pc", pc_addr, 0);
        chk("R9 ifid", ifid_instr, 0);
        chk("R9 idex ctrl", {24'd0, idex_ctrl}, 0);
        chk("R9 idex regs", {22'd0, idex_rs, idex_rt}, 0);
        chk("R3 stall after reset", {31'd0, stall}, 0);

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            load_prog(VECS[v].first, VECS[v].second, 32'h0);
            do_reset();
            refetch();
            step();
            chk("R6 ifid load", ifid_instr, VECS[v].first);
            chk("R6 pc step", pc_addr, 4);
            step();
            chk("R7 decode", {24'd0, idex_ctrl}, {24'd0, exp_ctrl(VECS[v].first)});
            chk("R1/R2/R3 stall", {31'd0, stall}, {31'd0, VECS[v].stall});
            chk("R4 write enables", {30'd0, pc_we, ifid_we}, VECS[v].stall ? 0 : 3);
            step();
            if (VECS[v].stall) begin
                chk("R5 bubble", {24'd0, idex_ctrl}, 0);
                chk("R4 pc held", pc_addr, 8);
                chk("R4 ifid held", ifid_instr, VECS[v].second);
            end else begin
                chk("R6 ctrl pass", {24'd0, idex_ctrl}, {24'd0, exp_ctrl(VECS[v].second)});
                chk("R6 rs/rt pass", {22'd0, idex_rs, idex_rt},
                    {22'd0, VECS[v].second[25:21], VECS[v].second[20:16]});
                chk("R6 pc advance", pc_addr, 12);
            end
        end

        // R8: load, then two dependent instructions in a row
        load_prog(enc(6'h23, 5'd3, 5'd2, 5'd0),
                  enc(6'h00, 5'd2, 5'd5, 5'd12),
                  enc(6'h00, 5'd12, 5'd2, 5'd13));
        do_reset();
        refetch();
        nstall = 0;
        for (int s = 0; s < 8; s++) begin
            step();
            if (stall) nstall++;
        end
        chk("R8 one bubble", nstall, 1);
        chk("R8 pc after chain", pc_addr, 28);

        // R9: reset in the middle of a run
        rst_n = 1'b0;
        step();
        chk("R9 mid-run pc", pc_addr, 0);
        chk("R9 mid-run ifid", ifid_instr, 0);
        chk("R9 mid-run idex", {19'd0, idex_ctrl, idex_rs}, 0);
        rst_n = 1'b1;

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule